// File: doc/BRIEF.md
# Iterative Non-Restoring Square Root Unit

This unit computes the integer square root of an unsigned radicand of 2N bits and returns a root of N+X bits. X is the number of extra fractional bits. The result equals floor(sqrt(radicand * 4^X)), so the low X bits of the root carry the fraction. The unit resolves one root bit per clock cycle, most significant first, with a single shared add/subtract path that is reused every cycle.

A one-cycle start pulse captures the radicand and clears the working state. The controller then runs N+X steps. In each step, two radicand bits shift into the partial remainder. Once the real radicand bits are used up, pairs of zeros shift in, so the radicand register never grows to hold the fractional padding. The done output rises when the last bit is resolved. Done and the root then hold until the next start pulse. No remainder is given out.

The two low bits of every step are fixed by the current radicand pair alone, and so is the carry into the upper adder. This leaves an adder of N+X bits with a carry-in in place of one that is two bits wider.

Top module: `nrsqrt_iter`

## Requirements
- R1: While reset is held and on the first cycle after it, done is 0 and root is 0.
- R2: When done rises, root equals floor(sqrt(radicand * 4^X)), where radicand is the value captured with the start pulse. This holds for every 2N-bit radicand.
- R3: Done rises at the clock edge exactly N+X cycles after the edge at which start was sampled high while idle.
- R4: Once high, done stays high and root keeps its value until start is sampled high again.
- R5: A start pulse that arrives while a computation is running is ignored. The running result and its timing are unchanged.
- R6: The radicand input is sampled only at the start edge. Changes to it during a computation have no effect on the result.
- R7: A start pulse while done is high begins a new computation, and done reads 0 after that edge.
- R8: A radicand of 0 gives root 0, and the all-ones radicand gives root 2^(N+X)-1.
- R9: Root bits resolve most significant first. After k steps of a run, root equals the final root shifted right by N+X-k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a computation; ignored while busy |
| radicand | input | 2N | Unsigned value, sampled with start |
| root | output | N+X | Root register; partial while running, final once done is high |
| done | output | 1 | Result valid; held until the next start |

## Verification
The assertions assume that start is a synchronous level: the controller sees it only at clock edges, and a start pulse may arrive in any state. The done-hold property relies on start staying low after a result. The stimulus changes start and radicand only on falling clock edges. It holds start low between requests, except for the deliberate pulses that probe busy-time starts and back-to-back restarts. The radicand input is scrambled during every run, which exercises R6.

// File: rtl/nrsqrt_pkg.sv
package nrsqrt_pkg;
  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/nrsqrt_step.sv
// One non-restoring step: reduced adder plus the two fixed low bits.
module nrsqrt_step #(
  parameter int unsigned NQ = 12
) (
  input  logic [NQ-1:0] rem_in,
  input  logic [NQ-1:0] root_in,
  input  logic [1:0]    pair,
  input  logic          sub,
  output logic [NQ-1:0] rem_out,
  output logic          bit_out,
  output logic          headroom_ok
);
  logic          cin;
  logic [1:0]    low;
  logic [NQ-1:0] opb;
  logic [NQ-1:0] upper;

  // Low pair is pair minus one (mod 4) for both operations.
  // Carry into the upper part is the OR of the pair in both modes.
  always_comb begin
    cin   = pair[1] | pair[0];
    low   = {pair[1] ~^ pair[0], ~pair[0]};
    opb   = sub ? ~root_in : root_in;
    upper = rem_in + opb + {{(NQ-1){1'b0}}, cin};
  end

  assign bit_out     = ~upper[NQ-1];
  assign headroom_ok = (upper[NQ-1] == upper[NQ-2]);

  generate
    if (NQ > 2) begin : g_wide
      assign rem_out = {upper[NQ-3:0], low};
    end else begin : g_narrow
      assign rem_out = low;
    end
  endgenerate
endmodule

// File: rtl/nrsqrt_ctrl.sv
module nrsqrt_ctrl
  import nrsqrt_pkg::*;
#(
  parameter int unsigned NQ = 12,
  localparam int unsigned CW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);
  localparam logic [CW-1:0] CNT_TOP = CW'(NQ - 1);

  ctl_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    load    = 1'b0;
    step    = 1'b0;
    last    = 1'b0;
    unique case (state_q)
      CTL_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = CNT_TOP;
          done_d  = 1'b0;
          state_d = CTL_RUN;
        end
      end
      CTL_RUN: begin
        step = 1'b1;
        if (cnt_q == '0) begin
          last    = 1'b1;
          done_d  = 1'b1;
          state_d = CTL_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state_q == CTL_RUN && cnt_q == '0));
  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> done_q);
  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CTL_RUN && cnt_q != '0) |=> (state_q == CTL_RUN && cnt_q == $past(cnt_q) - 1'b1));
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CTL_IDLE && start) |=> (!done_q && state_q == CTL_RUN));
endmodule

// File: rtl/nrsqrt_dp.sv
module nrsqrt_dp #(
  parameter int unsigned N  = 8,
  parameter int unsigned NQ = 12,
  localparam int unsigned DW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          last,
  input  logic [DW-1:0] rad_in,
  output logic [NQ-1:0] root
);
  logic [DW-1:0] rad_q, rad_d;
  logic [NQ-1:0] rem_q, rem_d;
  logic [NQ-1:0] root_q, root_d;
  logic          sub_q, sub_d;
  logic [NQ-1:0] rem_step;
  logic          bit_step;
  logic          headroom_ok;

  nrsqrt_step #(.NQ(NQ)) i_step (
    .rem_in      (rem_q),
    .root_in     (root_q),
    .pair        (rad_q[DW-1:DW-2]),
    .sub         (sub_q),
    .rem_out     (rem_step),
    .bit_out     (bit_step),
    .headroom_ok (headroom_ok)
  );

  always_comb begin
    rad_d  = rad_q;
    rem_d  = rem_q;
    root_d = root_q;
    sub_d  = sub_q;
    if (load) begin
      rad_d  = rad_in;
      rem_d  = '0;
      root_d = '0;
      sub_d  = 1'b1;  // first step subtracts
    end else if (step) begin
      rad_d  = {rad_q[DW-3:0], 2'b00};
      rem_d  = rem_step;
      root_d = {root_q[NQ-2:0], bit_step};
      sub_d  = bit_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      sub_q  <= 1'b1;
    end else if (load || step) begin
      rad_q  <= rad_d;
      rem_q  <= rem_d;
      root_q <= root_d;
      sub_q  <= sub_d;
    end
  end

  assign root = root_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |-> headroom_ok);
  assert_msb_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (root_q[NQ-1:1] == $past(root_q[NQ-2:0])));
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (root_q == '0 && sub_q));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(root_q));
endmodule

// File: rtl/nrsqrt_iter.sv
module nrsqrt_iter #(
  parameter int unsigned N = 8,
  parameter int unsigned X = 4,
  localparam int unsigned NQ = N + X,
  localparam int unsigned DW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] radicand,
  output logic [NQ-1:0] root,
  output logic          done
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       load, step, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  nrsqrt_ctrl #(.NQ(NQ)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .done  (done)
  );

  nrsqrt_dp #(.N(N), .NQ(NQ)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (load),
    .step   (step),
    .last   (last),
    .rad_in (radicand),
    .root   (root)
  );

  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(load && step));
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n_int |-> (!done && root == '0));
endmodule

// File: tb/test_nrsqrt_iter.sv
module test_nrsqrt_iter;
  localparam int unsigned N  = 8;
  localparam int unsigned X  = 4;
  localparam int unsigned NQ = N + X;
  localparam int unsigned DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] radicand = '0;
  logic [NQ-1:0] root;
  logic          done;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  logic done_prev = 1'b0;
  logic [NQ-1:0] exp_q[$];
  longint        tim_q[$];

  always #4ns clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  nrsqrt_iter #(.N(N), .X(X)) i_nrsqrt_iter (
    .clk(clk), .rst_n(rst_n), .start(start),
    .radicand(radicand), .root(root), .done(done)
  );

  function automatic logic [NQ-1:0] ref_root(logic [DW-1:0] d);
    logic [63:0] v;
    logic [NQ-1:0] r;
    v = 64'(d) << (2 * X);
    r = '0;
    for (int b = NQ - 1; b >= 0; b--) begin
      logic [NQ-1:0] c;
      c = r | (NQ'(1) << b);
      if (64'(c) * 64'(c) <= v) r = c;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected result", longint'(root), -1);
      end else begin
        logic [NQ-1:0] e;
        longint t;
        e = exp_q.pop_front();
        t = tim_q.pop_front();
        check(root == e, "R2 root", longint'(root), longint'(e));
        check(cyc - t == NQ, "R3 latency", cyc - t, NQ);
      end
    end
    done_prev <= done;
  end

  // Driver: issue one request and push its expectation.
  task automatic issue(input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1;
    radicand = d;
    exp_q.push_back(ref_root(d));
    tim_q.push_back(cyc + 1);
    @(negedge clk);
    start = 1'b0;
    radicand = DW'($urandom);  // R6: scrambled while running
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_one(input logic [DW-1:0] d);
    issue(d);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NQ-1:0] e;
    // R1 reset
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(root == '0, "R1 root in reset", root, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(root == '0, "R1 root after reset", root, 0);
    repeat (3) @(negedge clk);

    // R8 extremes
    run_one('0);
    check(root == '0, "R8 zero radicand", root, 0);
    run_one('1);
    check(root == {NQ{1'b1}}, "R8 all-ones radicand", root, longint'({NQ{1'b1}}));
    run_one(DW'(1));
    run_one(DW'(1) << (DW - 1));

    // R4 hold after done
    run_one(DW'(12345));
    e = ref_root(DW'(12345));
    repeat (5) begin
      @(negedge clk);
      check(done && root == e, "R4 hold", longint'(root), longint'(e));
    end

    // R7 restart clears done
    @(negedge clk);
    start = 1'b1;
    radicand = DW'(999);
    exp_q.push_back(ref_root(DW'(999)));
    tim_q.push_back(cyc + 1);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7 done cleared by restart", done, 0);
    wait_done();

    // R9 MSB-first partial root
    e = ref_root(DW'(50000));
    issue(DW'(50000));
    for (int k = 1; k <= int'(NQ); k++) begin
      @(negedge clk);
      if (k < int'(NQ))
        check(root == (e >> (NQ - k)), "R9 partial root", longint'(root), longint'(e >> (NQ - k)));
    end
    wait_done();

    // R5 start while busy ignored
    issue(DW'(40000));
    repeat (3) @(negedge clk);
    start = 1'b1;
    radicand = DW'(7);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    e = ref_root(DW'(40000));
    check(root == e, "R5 busy start ignored", longint'(root), longint'(e));
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 no extra result", exp_q.size(), 0);

    // R6 radicand changes mid-run
    issue(DW'(31337));
    repeat (4) begin
      @(negedge clk);
      radicand = DW'($urandom);
    end
    wait_done();
    e = ref_root(DW'(31337));
    check(root == e, "R6 radicand ignored while busy", longint'(root), longint'(e));

    // R2 random sweep, back-to-back
    for (int i = 0; i < 1500; i++) run_one(DW'($urandom));
    // R2 low values sweep
    for (int i = 0; i < 64; i++) run_one(DW'(i));

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule